// File: doc/BRIEF.md
# Flag-Suppressing Integer ALU with Redirected Writeback

This block is a single-cycle integer execution and writeback stage. It owns a 32-entry, 64-bit general-purpose register file and a four-bit condition-flags register. Each operation names two source registers, a separate destination index and an optional immediate. It also carries two control bits. One bit stops the flags from being updated. The other sends the result to the separate destination instead of back into the first operand.

Five operations are supported: increment, subtract, exclusive-or, a signed multiply that keeps the low half, and a conditional byte set. Each runs at an operand width of 8, 16, 32 or 64 bits. When a result is narrower than the register, the writeback either keeps the old upper bits of the destination (merge) or zeroes them (clear). Which one applies depends on the width and on the redirect bit. Multiply and conditional set never take the separate destination. For them the redirect bit only selects merge or clear.

Each accepted operation updates the register file and the flags at one clock edge. The same edge registers the write onto the output port, so the write becomes visible there one cycle after the operation was presented. The next operation already reads the new register contents.

Top module: `nfx_alu_top`

## Requirements
- R1: After reset all 32 registers hold zero, out_flags is 0 and wb_en is low. An operation presented with in_valid high is written into the register file at that clock edge and shows on wb_en/wb_idx/wb_data from that edge on. wb_en is low after any edge without in_valid.
- R2: With in_nf=1, out_flags keeps its previous value after the operation.
- R3: out_flags bit 0 is carry, bit 1 zero, bit 2 sign and bit 3 overflow. With in_nf=0, increment, subtract and exclusive-or set zero and sign from the result at the operation width. Subtract sets carry on unsigned borrow and sets overflow on signed overflow. Exclusive-or clears carry and overflow. Increment keeps carry and sets overflow when its operand was the largest positive value.
- R4: in_op encodes 0 increment, 1 subtract, 2 exclusive-or, 3 multiply and 4 conditional set. With in_nd=1, subtract and exclusive-or write (src1 op second operand) to in_dst, and both source registers keep their contents.
- R5: Increment with in_nd=1 writes src1+1 to in_dst and leaves src1 unchanged.
- R6: With in_nd=0, every operation writes its result back to in_src1.
- R7: in_size encodes 0 as 8, 1 as 16, 2 as 32 and 3 as 64 bits. A 32-bit result always has bits 63:32 zero, and a 64-bit result fills the whole register.
- R8: An 8- or 16-bit increment, subtract or exclusive-or with in_nd=1 writes zeros above the operand width.
- R9: An 8- or 16-bit operation with in_nd=0 keeps the destination's previous bits above the operand width.
- R10: Multiply and conditional set always write in_src1, whatever in_nd is. With in_nd=0 they merge as in R9, and with in_nd=1 they clear the upper bits as in R8.
- R11: in_nf=1 together with in_nd=1 gives a write to in_dst while the flags stay unchanged.
- R12: Conditional set ignores in_size and works on 8 bits. Its low byte is 1 when the condition holds and 0 otherwise. in_cc[3:1] picks the condition: 0 overflow, 1 carry, 2 zero, 3 carry or zero, 4 sign, 5 sign xor overflow, 6 zero or (sign xor overflow), 7 always. in_cc[0]=1 inverts the condition. The flags never change on a conditional set.
- R13: Multiply writes the low half of the signed product at the operation width. It sets carry and overflow when the signed product does not fit that width, and sets zero and sign from the truncated result.
- R14: With in_use_imm=1, the second operand is the low width bits of in_imm instead of register in_src2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation code |
| in_size | input | 2 | Operand width code |
| in_src1 | input | 5 | First source and home destination |
| in_src2 | input | 5 | Second source register |
| in_dst | input | 5 | Redirected destination register |
| in_imm | input | 64 | Immediate second operand |
| in_use_imm | input | 1 | Take second operand from in_imm |
| in_nf | input | 1 | Suppress flags update |
| in_nd | input | 1 | Redirect result / clear narrow upper bits |
| in_cc | input | 4 | Condition code for conditional set |
| wb_en | output | 1 | Register write performed at last edge |
| wb_idx | output | 5 | Register written |
| wb_data | output | 64 | Full 64-bit value written |
| out_flags | output | 4 | Flags {overflow, sign, zero, carry} |

## Verification
A wrong register value stays hidden until some later operation reads it. It then shows up in that operation's wb_data, which can be many operations later, so the bench keeps a full model of all registers and checks every write. A wrong flags state is visible on out_flags one cycle after the operation that caused it. It also shows up later in the byte written by a conditional set. A wrong merge/clear choice or a wrong destination choice shows on wb_data or wb_idx in the very next cycle.

// File: rtl/nfx_pkg.sv
package nfx_pkg;

    typedef enum logic [2:0] {
        OP_INC = 3'd0,
        OP_SUB = 3'd1,
        OP_XOR = 3'd2,
        OP_MUL = 3'd3,
        OP_SET = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        SZ8  = 2'd0,
        SZ16 = 2'd1,
        SZ32 = 2'd2,
        SZ64 = 2'd3
    } size_e;

    typedef struct packed {
        logic o;
        logic s;
        logic z;
        logic c;
    } flags_t;

    // cc[3:1] picks a base condition, cc[0] inverts it
    function automatic logic cond_hit(flags_t f, logic [3:0] cc);
        logic base;
        case (cc[3:1])
            3'd0:    base = f.o;
            3'd1:    base = f.c;
            3'd2:    base = f.z;
            3'd3:    base = f.c | f.z;
            3'd4:    base = f.s;
            3'd5:    base = f.s ^ f.o;
            3'd6:    base = f.z | (f.s ^ f.o);
            default: base = 1'b1;
        endcase
        return base ^ cc[0];
    endfunction

endpackage

// File: rtl/nfx_regfile.sv
module nfx_regfile #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] rd_a_idx,
    output logic [XLEN-1:0] rd_a_data,
    input  logic [IDXW-1:0] rd_b_idx,
    output logic [XLEN-1:0] rd_b_data,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [XLEN-1:0] wr_data
);

    logic [XLEN-1:0] mem [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_a_data = mem[rd_a_idx];
    assign rd_b_data = mem[rd_b_idx];

endmodule

// File: rtl/nfx_compute.sv
module nfx_compute
    import nfx_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int PW = 2 * XLEN
) (
    input  op_e             op,
    input  size_e           size,
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  flags_t          flags_in,
    input  logic [3:0]      cc,
    output logic [XLEN-1:0] res,
    output flags_t          flags_out
);

    logic [XLEN-1:0]        mask;
    logic [XLEN-1:0]        am;
    logic [XLEN-1:0]        bm;
    logic [XLEN-1:0]        inc_r;
    logic [XLEN-1:0]        sub_r;
    logic [XLEN-1:0]        mul_r;
    logic [XLEN:0]          diff;
    logic signed [PW-1:0]   wa;
    logic signed [PW-1:0]   wb;
    logic signed [PW-1:0]   prod;
    logic                   mul_ovf;
    logic                   cond;

    function automatic logic top_bit(logic [XLEN-1:0] v, size_e sz);
        logic t;
        case (sz)
            SZ8:     t = v[7];
            SZ16:    t = v[15];
            SZ32:    t = v[31];
            default: t = v[XLEN-1];
        endcase
        return t;
    endfunction

    function automatic logic [PW-1:0] widen(logic [XLEN-1:0] v, size_e sz);
        logic [PW-1:0] t;
        case (sz)
            SZ8:     t = {{(PW-8){v[7]}}, v[7:0]};
            SZ16:    t = {{(PW-16){v[15]}}, v[15:0]};
            SZ32:    t = {{(PW-32){v[31]}}, v[31:0]};
            default: t = {{XLEN{v[XLEN-1]}}, v};
        endcase
        return t;
    endfunction

    always_comb begin
        case (size)
            SZ8:     mask = {{(XLEN-8){1'b0}}, 8'hFF};
            SZ16:    mask = {{(XLEN-16){1'b0}}, 16'hFFFF};
            SZ32:    mask = {{(XLEN-32){1'b0}}, 32'hFFFF_FFFF};
            default: mask = '1;
        endcase
    end

    assign am    = opnd_a & mask;
    assign bm    = opnd_b & mask;

    assign inc_r = (am + XLEN'(1)) & mask;
    assign diff  = {1'b0, am} - {1'b0, bm};
    assign sub_r = diff[XLEN-1:0] & mask;

    assign wa      = $signed(widen(am, size));
    assign wb      = $signed(widen(bm, size));
    assign prod    = wa * wb;
    assign mul_r   = prod[XLEN-1:0] & mask;
    assign mul_ovf = (prod != $signed(widen(mul_r, size)));

    assign cond = cond_hit(flags_in, cc);

    always_comb begin
        flags_out = flags_in;
        res       = '0;
        unique case (op)
            OP_INC: begin
                res         = inc_r;
                flags_out.o = !top_bit(am, size) && top_bit(inc_r, size);
            end
            OP_SUB: begin
                res         = sub_r;
                flags_out.c = diff[XLEN];
                flags_out.o = (top_bit(am, size) != top_bit(bm, size)) &&
                              (top_bit(sub_r, size) != top_bit(am, size));
            end
            OP_XOR: begin
                res         = am ^ bm;
                flags_out.c = 1'b0;
                flags_out.o = 1'b0;
            end
            OP_MUL: begin
                res         = mul_r;
                flags_out.c = mul_ovf;
                flags_out.o = mul_ovf;
            end
            OP_SET: begin
                res = {{(XLEN-1){1'b0}}, cond};
            end
            default: begin
                res = '0;
            end
        endcase
        if (op != OP_SET) begin
            flags_out.z = (res == '0);
            flags_out.s = top_bit(res, size);
        end
    end

endmodule

// File: rtl/nfx_writeback.sv
module nfx_writeback
    import nfx_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  op_e             op,
    input  size_e           size,
    input  logic            nd,
    input  logic [IDXW-1:0] home_idx,
    input  logic [IDXW-1:0] alt_idx,
    input  logic [XLEN-1:0] res,
    input  logic [XLEN-1:0] old_val,
    output logic [IDXW-1:0] wr_idx,
    output logic [XLEN-1:0] wr_data
);

    logic            redirect;
    logic [XLEN-1:0] keep;

    // only the arithmetic/logic forms may take a separate destination
    assign redirect = nd && (op == OP_INC || op == OP_SUB || op == OP_XOR);

    always_comb begin
        keep = '0;
        if (!nd) begin
            case (size)
                SZ8:     keep = ~{{(XLEN-8){1'b0}}, 8'hFF};
                SZ16:    keep = ~{{(XLEN-16){1'b0}}, 16'hFFFF};
                default: keep = '0;
            endcase
        end
    end

    assign wr_idx  = redirect ? alt_idx : home_idx;
    assign wr_data = res | (old_val & keep);

endmodule

// File: rtl/nfx_alu_top.sv
module nfx_alu_top
    import nfx_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      in_op,
    input  logic [1:0]      in_size,
    input  logic [IDXW-1:0] in_src1,
    input  logic [IDXW-1:0] in_src2,
    input  logic [IDXW-1:0] in_dst,
    input  logic [XLEN-1:0] in_imm,
    input  logic            in_use_imm,
    input  logic            in_nf,
    input  logic            in_nd,
    input  logic [3:0]      in_cc,
    output logic            wb_en,
    output logic [IDXW-1:0] wb_idx,
    output logic [XLEN-1:0] wb_data,
    output logic [3:0]      out_flags
);

    op_e             op;
    size_e           eff_size;
    logic [XLEN-1:0] rf_a;
    logic [XLEN-1:0] rf_b;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] res;
    flags_t          flags_q;
    flags_t          flags_new;
    logic [IDXW-1:0] wr_idx;
    logic [XLEN-1:0] wr_data;
    logic            flags_upd;

    assign op       = op_e'(in_op);
    assign eff_size = (op == OP_SET) ? SZ8 : size_e'(in_size);
    assign opnd_b   = in_use_imm ? in_imm : rf_b;

    nfx_regfile #(.XLEN(XLEN), .NREG(NREG)) i_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (in_src1),
        .rd_a_data (rf_a),
        .rd_b_idx  (in_src2),
        .rd_b_data (rf_b),
        .wr_en     (in_valid),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    nfx_compute #(.XLEN(XLEN)) i_compute (
        .op        (op),
        .size      (eff_size),
        .opnd_a    (rf_a),
        .opnd_b    (opnd_b),
        .flags_in  (flags_q),
        .cc        (in_cc),
        .res       (res),
        .flags_out (flags_new)
    );

    nfx_writeback #(.XLEN(XLEN), .NREG(NREG)) i_writeback (
        .op       (op),
        .size     (eff_size),
        .nd       (in_nd),
        .home_idx (in_src1),
        .alt_idx  (in_dst),
        .res      (res),
        .old_val  (rf_a),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    assign flags_upd = in_valid && !in_nf && (op != OP_SET);

    // flags state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (flags_upd) begin
            flags_q <= flags_new;
        end
    end

    // writeback output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_en   <= 1'b0;
            wb_idx  <= '0;
            wb_data <= '0;
        end else begin
            wb_en <= in_valid;
            if (in_valid) begin
                wb_idx  <= wr_idx;
                wb_data <= wr_data;
            end
        end
    end

    assign out_flags = flags_q;

endmodule

// File: rtl/nfx_alu_chk.sv
module nfx_alu_chk #(
    parameter int XLEN = 64,
    parameter int NREG = 32,
    localparam int IDXW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [2:0]      in_op,
    input logic [1:0]      in_size,
    input logic [IDXW-1:0] in_src1,
    input logic [IDXW-1:0] in_src2,
    input logic [IDXW-1:0] in_dst,
    input logic            in_use_imm,
    input logic            in_nf,
    input logic            in_nd,
    input logic            wb_en,
    input logic [IDXW-1:0] wb_idx,
    input logic [XLEN-1:0] wb_data,
    input logic [3:0]      out_flags
);

    AST_WB_FOLLOWS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> wb_en); // R1

    AST_WB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !wb_en); // R1

    AST_NF_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_nf) |=> (out_flags == $past(out_flags))); // R2

    AST_SET_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 3'd4) |=> (out_flags == $past(out_flags))); // R12

    AST_ND_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_nd && in_op < 3'd3) |=> (wb_idx == $past(in_dst))); // R4

    AST_HOME_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!in_nd || in_op == 3'd3 || in_op == 3'd4))
        |=> (wb_idx == $past(in_src1))); // R10

    AST_WIDE32_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 3'd4 && in_size == 2'd2)
        |=> (wb_data[XLEN-1:32] == '0)); // R7

    AST_ND_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_nd && in_op != 3'd4 && in_size == 2'd0)
        |=> (wb_data[XLEN-1:8] == '0)); // R8

    AST_SET_ND_BIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_nd && in_op == 3'd4) |=> (wb_data[XLEN-1:1] == '0)); // R10

    AST_XOR_SELF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_nd && in_op == 3'd2 && !in_use_imm && in_src1 == in_src2)
        |=> (wb_data == '0)); // R4

endmodule

bind nfx_alu_top nfx_alu_chk #(.XLEN(XLEN), .NREG(NREG)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_size    (in_size),
    .in_src1    (in_src1),
    .in_src2    (in_src2),
    .in_dst     (in_dst),
    .in_use_imm (in_use_imm),
    .in_nf      (in_nf),
    .in_nd      (in_nd),
    .wb_en      (wb_en),
    .wb_idx     (wb_idx),
    .wb_data    (wb_data),
    .out_flags  (out_flags)
);

// File: tb/test_nfx_alu_top.sv
`timescale 1ns/1ps
module test_nfx_alu_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  in_op;
    logic [1:0]  in_size;
    logic [4:0]  in_src1;
    logic [4:0]  in_src2;
    logic [4:0]  in_dst;
    logic [63:0] in_imm;
    logic        in_use_imm;
    logic        in_nf;
    logic        in_nd;
    logic [3:0]  in_cc;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [63:0] wb_data;
    logic [3:0]  out_flags;

    logic [63:0] rf_m [32];
    logic [3:0]  fl_m;
    int          total = 0;
    int          bad = 0;

    always #2.5 clk = ~clk;

    nfx_alu_top i_nfx_alu_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_size    (in_size),
        .in_src1    (in_src1),
        .in_src2    (in_src2),
        .in_dst     (in_dst),
        .in_imm     (in_imm),
        .in_use_imm (in_use_imm),
        .in_nf      (in_nf),
        .in_nd      (in_nd),
        .in_cc      (in_cc),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data),
        .out_flags  (out_flags)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] wmask(int sz);
        return (sz == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << sz)) - 64'd1);
    endfunction

    function automatic logic [127:0] sx(logic [63:0] v, int w);
        logic [127:0] t;
        t = {64'd0, v};
        if (v[w-1]) t = t | ~((128'd1 << w) - 128'd1);
        return t;
    endfunction

    function automatic bit cond_m(logic [3:0] f, logic [3:0] cc);
        bit c, z, s, o;
        c = f[0]; z = f[1]; s = f[2]; o = f[3];
        case (cc)
            4'd0:  return o;
            4'd1:  return !o;
            4'd2:  return c;
            4'd3:  return !c;
            4'd4:  return z;
            4'd5:  return !z;
            4'd6:  return c | z;
            4'd7:  return !(c | z);
            4'd8:  return s;
            4'd9:  return !s;
            4'd10: return s != o;
            4'd11: return s == o;
            4'd12: return z | (s != o);
            4'd13: return !(z | (s != o));
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run_op(input int op, input int sz, input int s1, input int s2,
                          input int d, input logic [63:0] imm, input bit ui,
                          input bit nf, input bit nd, input logic [3:0] cc,
                          input string tag);
        logic [63:0]  m, a, b, am, bm, r, data;
        logic [127:0] p;
        int           esz, w, idx;
        bit           c, o, z, s;
        string        ftag;
        @(negedge clk);
        in_op = 3'(op); in_size = 2'(sz); in_src1 = 5'(s1); in_src2 = 5'(s2);
        in_dst = 5'(d); in_imm = imm; in_use_imm = ui; in_nf = nf; in_nd = nd;
        in_cc = cc; in_valid = 1'b1;
        esz = (op == 4) ? 0 : sz;
        w   = 8 << esz;
        m   = wmask(esz);
        a   = rf_m[s1];
        b   = ui ? imm : rf_m[s2];
        am  = a & m;
        bm  = b & m;
        c   = fl_m[0];
        o   = fl_m[3];
        p   = '0;
        case (op)
            0: begin r = (am + 64'd1) & m; o = (am == (m >> 1)); end
            1: begin
                r = (am - bm) & m;
                c = (am < bm);
                o = (am[w-1] != bm[w-1]) && (r[w-1] != am[w-1]);
            end
            2: begin r = am ^ bm; c = 1'b0; o = 1'b0; end
            3: begin
                p = sx(am, w) * sx(bm, w);
                r = p[63:0] & m;
                o = (p != sx(r, w));
                c = o;
            end
            default: r = cond_m(fl_m, cc) ? 64'd1 : 64'd0;
        endcase
        z    = (r == 64'd0);
        s    = r[w-1];
        idx  = (nd && op < 3) ? d : s1;
        data = (esz >= 2 || nd) ? r : ((rf_m[s1] & ~m) | r);
        rf_m[idx] = data;
        if (!nf && op != 4) fl_m = {o, s, z, c};
        ftag = (op == 4) ? "R12" : (nf ? "R2" : ((op == 3) ? "R13" : "R3"));
        @(negedge clk);
        in_valid = 1'b0;
        check(wb_en && wb_idx == 5'(idx), tag, "write index", {59'd0, wb_idx}, 64'(idx));
        check(wb_data == data, tag, "write data", wb_data, data);
        check(out_flags == fl_m, ftag, "flags", {60'd0, out_flags}, {60'd0, fl_m});
    endtask

    // load a register through subtract-with-redirect from zero register 0
    task automatic set_reg(input int rg, input logic [63:0] val);
        run_op(1, 3, 0, 0, rg, 64'd0 - val, 1'b1, 1'b1, 1'b1, 4'd0, "R14");
    endtask

    // copy a register into scratch register 30 so its value shows on wb_data
    task automatic peek(input int rg, input string tag);
        run_op(1, 3, rg, 0, 30, 64'd0, 1'b1, 1'b1, 1'b1, 4'd0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) rf_m[i] = 64'd0;
        fl_m = 4'd0;
        rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_size = '0; in_src1 = '0;
        in_src2 = '0; in_dst = '0; in_imm = '0; in_use_imm = 1'b0; in_nf = 1'b0;
        in_nd = 1'b0; in_cc = '0;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!wb_en, "R1", "reset wb_en", {63'd0, wb_en}, 64'd0);
        check(out_flags == 4'd0, "R1", "reset flags", {60'd0, out_flags}, 64'd0);
        peek(17, "R1");

        set_reg(1, 64'h8899_AABB_CCDD_EEFF);
        set_reg(2, 64'h0123_4567_89AB_CDEF);
        run_op(1, 0, 1, 0, 0, 64'h01, 1'b1, 1'b0, 1'b0, 4'd0, "R9");
        run_op(1, 1, 1, 2, 3, 64'd0, 1'b0, 1'b0, 1'b1, 4'd0, "R8");
        run_op(0, 2, 1, 0, 4, 64'd0, 1'b0, 1'b0, 1'b1, 4'd0, "R5");
        peek(1, "R5");
        run_op(2, 2, 2, 1, 2, 64'd0, 1'b0, 1'b0, 1'b0, 4'd0, "R7");
        run_op(2, 3, 1, 2, 2, 64'd0, 1'b0, 1'b0, 1'b0, 4'd0, "R6");
        set_reg(5, 64'h7F);
        run_op(1, 0, 0, 0, 6, 64'h1, 1'b1, 1'b0, 1'b1, 4'd0, "R3");
        run_op(0, 0, 5, 0, 5, 64'd0, 1'b0, 1'b0, 1'b0, 4'd0, "R3");
        run_op(2, 3, 1, 2, 7, 64'd0, 1'b0, 1'b1, 1'b1, 4'd0, "R11");
        peek(1, "R4");
        peek(2, "R4");
        run_op(2, 3, 1, 1, 8, 64'd0, 1'b0, 1'b0, 1'b1, 4'd0, "R4");
        set_reg(9, 64'hFFFF_FFFF_FFFF_4000);
        run_op(3, 1, 9, 0, 0, 64'h4, 1'b1, 1'b0, 1'b1, 4'd0, "R10");
        set_reg(10, 64'hAAAA_AAAA_AAAA_AA03);
        run_op(3, 0, 10, 0, 0, 64'hFE, 1'b1, 1'b0, 1'b0, 4'd0, "R13");
        set_reg(11, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op(4, 3, 11, 0, 12, 64'd0, 1'b0, 1'b0, 1'b0, 4'd9, "R12");
        run_op(4, 3, 11, 0, 12, 64'd0, 1'b0, 1'b0, 1'b1, 4'd14, "R10");
        run_op(4, 0, 11, 0, 0, 64'd0, 1'b0, 1'b1, 1'b0, 4'd15, "R12");
        run_op(1, 1, 2, 0, 13, 64'h7FFF_0001, 1'b1, 1'b0, 1'b1, 4'd0, "R14");
        @(negedge clk);
        check(!wb_en, "R1", "idle wb_en", {63'd0, wb_en}, 64'd0);

        for (int k = 0; k < 1500; k++) begin
            int    op, sz;
            string tg;
            op = int'($urandom_range(0, 4));
            sz = int'($urandom_range(0, 3));
            tg = (op == 4) ? "R12" : ((op == 3) ? "R10" : "R6");
            run_op(op, sz, int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                   int'($urandom_range(0, 31)), {$urandom, $urandom},
                   1'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), tg);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule